// File: doc/BRIEF.md
# Programmable-Level Interrupt Prioritizer

This block takes 64 interrupt request lines and gives each one a programmable 3-bit priority level. A source is a candidate when it is requested, either by its pending line or by a software force bit, and its mask bit is clear. Among the candidates the block picks the highest level. Inside that level it picks the highest-numbered source. It then compares the winning level with the processor's current mask level and drives the level out only when the winning level is strictly greater.

Software reaches the block through a small word-addressed register port. The mask, force and per-source level registers can be written and read back. Eight read-only acknowledge registers return vector numbers: one holds the overall winner, and seven hold the winner inside each level from 1 to 7. Writing to an acknowledge register produces an error response and changes nothing. The level output and all winners are registered, so they follow any input or register change after one clock.

Top module: `irq_level_arbiter`

## Requirements
- R1: Source k is active when (irq_pend[k] OR force[k]) AND NOT mask[k]. A set mask bit blocks both the pending line and the force bit.
- R2: A source whose level field is 0 never takes part in prioritization, even when it is active.
- R3: The overall winner is the active source with the highest level. When sources share that level, the higher source number wins.
- R4: irq_level equals the winning level when that level is strictly greater than cpu_mask, and 0 otherwise. It is registered one clock after the inputs or registers it depends on.
- R5: A read of the global acknowledge register (word address 8) returns 64 + k, where k is the overall winner, in bits 7:0. When no source qualifies it returns 0x18.
- R6: A read of the level-n acknowledge register (word address 8 + n, n = 1..7) returns 64 + k for the highest-numbered active source programmed to level n, or 0x18 when that level has no active source.
- R7: A write to any word address from 8 to 15 raises bus_err with the response and leaves every register unchanged.
- R8: After reset every mask bit is 1, every force bit is 0, every level field is 0 and irq_level is 0.
- R9: The writable registers have these word addresses: mask bits 31:0 at 0, mask bits 63:32 at 1, force bits 31:0 at 4, force bits 63:32 at 5, and the level of source k in bits 2:0 at 64 + k. Reads return the current contents. All other addresses read as 0.
- R10: bus_ack is high exactly one clock after a cycle with bus_valid high. bus_rdata carries the read value in that cycle and 0 for a write response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pend | input | 64 | Raw pending request per source |
| cpu_mask | input | 3 | Current processor interrupt mask level |
| irq_level | output | 3 | Registered unmasked priority level, 0 when nothing is signalled |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response strobe, one clock after the request |
| bus_err | output | 1 | Error response for a write to an acknowledge register |
| bus_rdata | output | 32 | Read data, valid with bus_ack |

## Verification
A wrong mask, force or level bit inside the block shows up one clock later as a wrong irq_level, and the acknowledge registers then return a wrong vector on the next read. The bench runs a reference model alongside the block and compares the level output and every bus response on every clock, so a corrupted winner register or a missed write is caught within one or two cycles of the stimulus that exposes it. Writes to the acknowledge registers are followed by read-backs of the writable registers, so a write that changes state without permission becomes visible at the ports.

// File: rtl/irq_arb_pkg.sv
// Package: word-address map shared by the register file, the read port,
// the checker and the bench. Assumes at most 64 sources, so the level
// fields fit in word addresses 64..127 of a 7-bit address.
package irq_arb_pkg;
    localparam int ADR_MASK  = 0;   // mask words start here
    localparam int ADR_FORCE = 4;   // force words start here
    localparam int ADR_SWACK = 8;   // global acknowledge; level n at +n
    localparam int ADR_LEVEL = 64;  // level field of source k at +k
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the writable state: per-source mask and force bits and per-source
// level fields. Decodes only its own addresses, so writes elsewhere
// (including acknowledge addresses) leave it untouched.
// Assumes NUM_SRC is a multiple of DATA_W and at most 4 words wide.
module irq_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_SRC-1:0]                mask_q,
    output logic [NUM_SRC-1:0]                force_q,
    output logic [NUM_SRC-1:0][LVL_W-1:0]     level_q
);
    localparam int NWORD = NUM_SRC / DATA_W;

    // Mask and force words: reset masks everything and clears forcing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            force_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NWORD; w++) begin
                if (wr_addr == ADDR_W'(ADR_MASK + w))
                    mask_q[w*DATA_W +: DATA_W] <= wr_data;
                if (wr_addr == ADDR_W'(ADR_FORCE + w))
                    force_q[w*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    // Level fields: one word address per source, reset to disabled (0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (wr_addr == ADDR_W'(ADR_LEVEL + k))
                    level_q[k] <= wr_data[LVL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
// Module: irq_prio_core
// Finds the active sources, the highest-numbered active source in every
// level, and the overall winner (highest level). Registers all winners and
// the level output compared against the processor mask. Level 0 is
// treated as disabled and has no winner slot.
module irq_prio_core #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3,
    parameter int NUM_LVL = 7,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                pend,
    input  logic [NUM_SRC-1:0]                mask,
    input  logic [NUM_SRC-1:0]                frc,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]     level,
    input  logic [LVL_W-1:0]                  cpu_mask,
    output logic [NUM_LVL-1:0]                lvl_vld_q,
    output logic [NUM_LVL-1:0][IDX_W-1:0]     lvl_idx_q,
    output logic                              glb_vld_q,
    output logic [IDX_W-1:0]                  glb_idx_q,
    output logic [LVL_W-1:0]                  irq_level_q
);
    logic [NUM_SRC-1:0]            active;
    logic [NUM_LVL-1:0]            lvl_vld_c;
    logic [NUM_LVL-1:0][IDX_W-1:0] lvl_idx_c;
    logic                          best_vld;
    logic [LVL_W-1:0]              best_lvl;
    logic [IDX_W-1:0]              best_idx;

    // Recognition: requested by line or force, and not masked.
    assign active = (pend | frc) & ~mask;

    // One scanner per level; later (higher) source numbers overwrite.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        logic             hit;
        logic [IDX_W-1:0] hit_idx;
        // Scan all sources for the highest-numbered one at level g+1.
        always_comb begin
            hit     = 1'b0;
            hit_idx = '0;
            for (int k = 0; k < NUM_SRC; k++) begin
                if (active[k] && level[k] == LVL_W'(g + 1)) begin
                    hit     = 1'b1;
                    hit_idx = IDX_W'(k);
                end
            end
        end
        assign lvl_vld_c[g] = hit;
        assign lvl_idx_c[g] = hit_idx;
    end

    // Overall winner: highest populated level overwrites lower ones.
    always_comb begin
        best_vld = 1'b0;
        best_lvl = '0;
        best_idx = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (lvl_vld_c[l]) begin
                best_vld = 1'b1;
                best_lvl = LVL_W'(l + 1);
                best_idx = lvl_idx_c[l];
            end
        end
    end

    // Register winners and the level signalled above the processor mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_vld_q   <= '0;
            lvl_idx_q   <= '0;
            glb_vld_q   <= 1'b0;
            glb_idx_q   <= '0;
            irq_level_q <= '0;
        end else begin
            lvl_vld_q   <= lvl_vld_c;
            lvl_idx_q   <= lvl_idx_c;
            glb_vld_q   <= best_vld;
            glb_idx_q   <= best_idx;
            irq_level_q <= (best_vld && best_lvl > cpu_mask) ? best_lvl : '0;
        end
    end
endmodule

// File: rtl/irq_ack_port.sv
// Module: irq_ack_port
// Register read port and response logic. Returns register contents or
// vector numbers one clock after a request; flags writes that target the
// acknowledge addresses with an error response.
module irq_ack_port
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int LVL_W     = 3,
    parameter int NUM_LVL   = 7,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 7,
    parameter int VEC_W     = 8,
    parameter int VEC_BASE  = 64,
    parameter int VEC_SPUR  = 24,
    parameter int IDX_W     = $clog2(NUM_SRC)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_valid,
    input  logic                              bus_write,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [NUM_SRC-1:0]                mask,
    input  logic [NUM_SRC-1:0]                frc,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]     level,
    input  logic [NUM_LVL-1:0]                lvl_vld,
    input  logic [NUM_LVL-1:0][IDX_W-1:0]     lvl_idx,
    input  logic                              glb_vld,
    input  logic [IDX_W-1:0]                  glb_idx,
    output logic                              bus_ack,
    output logic                              bus_err,
    output logic [DATA_W-1:0]                 bus_rdata
);
    localparam int NWORD = NUM_SRC / DATA_W;

    logic [DATA_W-1:0] rd_val;
    logic              is_ack_adr;

    // Vector number for a winner slot, spurious vector when empty.
    function automatic logic [VEC_W-1:0] vec_of(input logic v, input logic [IDX_W-1:0] i);
        return v ? (VEC_W'(VEC_BASE) + VEC_W'(i)) : VEC_W'(VEC_SPUR);
    endfunction

    // Acknowledge block: global at ADR_SWACK, levels right after it.
    assign is_ack_adr = (bus_addr >= ADDR_W'(ADR_SWACK)) &&
                        (bus_addr <= ADDR_W'(ADR_SWACK + NUM_LVL));

    // Read multiplexer over all readable addresses.
    always_comb begin
        rd_val = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (bus_addr == ADDR_W'(ADR_MASK + w))
                rd_val = mask[w*DATA_W +: DATA_W];
            if (bus_addr == ADDR_W'(ADR_FORCE + w))
                rd_val = frc[w*DATA_W +: DATA_W];
        end
        if (bus_addr == ADDR_W'(ADR_SWACK))
            rd_val = DATA_W'(vec_of(glb_vld, glb_idx));
        for (int l = 0; l < NUM_LVL; l++) begin
            if (bus_addr == ADDR_W'(ADR_SWACK + 1 + l))
                rd_val = DATA_W'(vec_of(lvl_vld[l], lvl_idx[l]));
        end
        for (int k = 0; k < NUM_SRC; k++) begin
            if (bus_addr == ADDR_W'(ADR_LEVEL + k))
                rd_val = DATA_W'(level[k]);
        end
    end

    // Response register: strobe, error flag and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_valid;
            bus_err   <= bus_valid && bus_write && is_ack_adr;
            bus_rdata <= (bus_valid && !bus_write) ? rd_val : '0;
        end
    end
endmodule

// File: rtl/irq_level_arbiter.sv
// Module: irq_level_arbiter (top)
// Programmable-level interrupt prioritizer: register file, priority core
// and acknowledge/read port. All outputs are registered.
module irq_level_arbiter #(
    parameter int NUM_SRC  = 64,
    parameter int LVL_W    = 3,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 7,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64,
    parameter int VEC_SPUR = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_pend,
    input  logic [LVL_W-1:0]     cpu_mask,
    output logic [LVL_W-1:0]     irq_level,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic                 bus_ack,
    output logic                 bus_err,
    output logic [DATA_W-1:0]    bus_rdata
);
    localparam int NUM_LVL = (1 << LVL_W) - 1;
    localparam int IDX_W   = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]            mask_q;
    logic [NUM_SRC-1:0]            force_q;
    logic [NUM_SRC-1:0][LVL_W-1:0] level_q;
    logic [NUM_LVL-1:0]            lvl_vld;
    logic [NUM_LVL-1:0][IDX_W-1:0] lvl_idx;
    logic                          glb_vld;
    logic [IDX_W-1:0]              glb_idx;

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_valid && bus_write),
        .wr_addr (bus_addr),
        .wr_data (bus_wdata),
        .mask_q  (mask_q),
        .force_q (force_q),
        .level_q (level_q)
    );

    irq_prio_core #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .NUM_LVL(NUM_LVL), .IDX_W(IDX_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (irq_pend),
        .mask        (mask_q),
        .frc         (force_q),
        .level       (level_q),
        .cpu_mask    (cpu_mask),
        .lvl_vld_q   (lvl_vld),
        .lvl_idx_q   (lvl_idx),
        .glb_vld_q   (glb_vld),
        .glb_idx_q   (glb_idx),
        .irq_level_q (irq_level)
    );

    irq_ack_port #(
        .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .NUM_LVL(NUM_LVL), .DATA_W(DATA_W),
        .ADDR_W(ADDR_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
        .VEC_SPUR(VEC_SPUR), .IDX_W(IDX_W)
    ) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .mask      (mask_q),
        .frc       (force_q),
        .level     (level_q),
        .lvl_vld   (lvl_vld),
        .lvl_idx   (lvl_idx),
        .glb_vld   (glb_vld),
        .glb_idx   (glb_idx),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: rtl/irq_level_arbiter_chk.sv
// Module: irq_level_arbiter_chk
// Property checker bound to irq_level_arbiter. Observes ports and the
// register-file outputs.
module irq_level_arbiter_chk #(
    parameter int NUM_SRC = 64,
    parameter int LVL_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_pend,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] force_q,
    input logic [LVL_W-1:0]   cpu_mask,
    input logic [LVL_W-1:0]   irq_level,
    input logic               bus_valid,
    input logic               bus_write,
    input logic               bus_ack,
    input logic               bus_err
);
    assert_level_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_level > $past(cpu_mask)));

    assert_no_active_no_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(((irq_pend | force_q) & ~mask_q) == '0)) |-> (irq_level == '0));

    assert_ack_follows_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> bus_ack);

    assert_ack_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_valid));

    assert_err_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid && bus_write));

    assert_err_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($stable(mask_q) && $stable(force_q)));

    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> ((&mask_q) && (force_q == '0) && (irq_level == '0)));
endmodule

bind irq_level_arbiter irq_level_arbiter_chk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pend  (irq_pend),
    .mask_q    (mask_q),
    .force_q   (force_q),
    .cpu_mask  (cpu_mask),
    .irq_level (irq_level),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err)
);

// File: tb/sim_irq_level_arbiter.sv
// Bench: behavioural reference model compared on every clock, plus
// directed scenarios per requirement.
module sim_irq_level_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_pend = '0;
    logic [2:0]  cpu_mask = '0;
    logic [2:0]  irq_level;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic        bus_err;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_level_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .cpu_mask(cpu_mask),
        .irq_level(irq_level), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    // ---------------- reference model ----------------
    bit [63:0] m_mask, m_force;
    int        m_lvl[64];
    int        m_win[8];     // winner per level 1..7, -1 none
    int        m_gwin;
    int        m_irq;
    bit        m_ack, m_err;
    bit [31:0] m_rdata;

    function automatic int vec_num(int idx);
        return (idx < 0) ? 24 : 64 + idx;
    endfunction

    function automatic bit [31:0] model_read(int a);
        if (a == 0) return m_mask[31:0];
        if (a == 1) return m_mask[63:32];
        if (a == 4) return m_force[31:0];
        if (a == 5) return m_force[63:32];
        if (a == 8) return 32'(vec_num(m_gwin));
        if (a >= 9 && a <= 15) return 32'(vec_num(m_win[a - 8]));
        if (a >= 64) return 32'(m_lvl[a - 64]);
        return 0;
    endfunction

    always @(posedge clk) begin : model
        int nw[8];
        int ng, nl;
        bit [31:0] rd;
        if (!rst_n) begin
            m_mask = '1; m_force = '0;
            foreach (m_lvl[k]) m_lvl[k] = 0;
            foreach (m_win[l]) m_win[l] = -1;
            m_gwin = -1; m_irq = 0; m_ack = 0; m_err = 0; m_rdata = 0;
        end else begin
            rd = model_read(int'(bus_addr));
            foreach (nw[l]) nw[l] = -1;
            for (int k = 0; k < 64; k++)
                if ((irq_pend[k] || m_force[k]) && !m_mask[k] && m_lvl[k] != 0)
                    nw[m_lvl[k]] = k;
            ng = -1; nl = 0;
            for (int l = 1; l < 8; l++) if (nw[l] >= 0) begin ng = nw[l]; nl = l; end
            m_ack   = bus_valid;
            m_err   = bus_valid && bus_write && bus_addr >= 8 && bus_addr <= 15;
            m_rdata = (bus_valid && !bus_write) ? rd : 0;
            m_irq   = (nl > int'(cpu_mask)) ? nl : 0;
            m_win   = nw;
            m_gwin  = ng;
            if (bus_valid && bus_write) begin
                if (bus_addr == 0) m_mask[31:0]  = bus_wdata;
                if (bus_addr == 1) m_mask[63:32] = bus_wdata;
                if (bus_addr == 4) m_force[31:0] = bus_wdata;
                if (bus_addr == 5) m_force[63:32] = bus_wdata;
                if (bus_addr >= 64) m_lvl[bus_addr - 64] = int'(bus_wdata[2:0]);
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Every-clock comparison against the model.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R4", "irq_level model", 32'(irq_level), 32'(m_irq));
            chk("R10", "bus_ack model", 32'(bus_ack), 32'(m_ack));
            chk("R7", "bus_err model", 32'(bus_err), 32'(m_err));
            chk("R9", "bus_rdata model", bus_rdata, m_rdata);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 7'(a); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_wdata = 0;
    endtask

    task automatic bus_rd(int a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 7'(a);
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        e;
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk_on = 1;
        step();
        // R8: reset state
        chk("R8", "irq_level after reset", 32'(irq_level), 0);
        bus_rd(0, d);  chk("R8", "mask low", d, 32'hffff_ffff);
        bus_rd(1, d);  chk("R8", "mask high", d, 32'hffff_ffff);
        bus_rd(5, d);  chk("R8", "force high", d, 0);
        bus_rd(74, d); chk("R8", "level src10", d, 0);
        bus_rd(8, d);  chk("R5", "swack spurious after reset", d, 32'h18);

        // R9: level write readback
        bus_wr(74, 32'h5); bus_rd(74, d); chk("R9", "level src10", d, 5);
        bus_wr(74, 32'h0);
        bus_rd(2, d); chk("R9", "unmapped addr reads 0", d, 0);

        // R3: four sources share level 3
        bus_wr(64 + 2, 3); bus_wr(64 + 8, 3); bus_wr(64 + 22, 3); bus_wr(64 + 40, 3);
        bus_wr(0, 32'h0); bus_wr(1, 32'h0);
        irq_pend = (64'd1 << 2) | (64'd1 << 8) | (64'd1 << 22) | (64'd1 << 40);
        bus_rd(8, d);  chk("R3", "tie goes to src40", d, 104);
        bus_rd(11, d); chk("R6", "level3 ack src40", d, 104);
        chk("R4", "irq_level 3", 32'(irq_level), 3);
        irq_pend[40] = 0;
        bus_rd(8, d);  chk("R3", "next winner src22", d, 86);

        // R1: force on a masked source has no effect
        bus_wr(64 + 5, 6);
        bus_wr(0, 32'h20);          // mask only src5
        bus_wr(4, 32'h20);          // force src5
        bus_rd(8, d);  chk("R1", "masked force ignored", d, 86);
        chk("R1", "irq_level stays 3", 32'(irq_level), 3);
        bus_wr(0, 32'h0);
        bus_rd(8, d);  chk("R1", "forced src5 wins", d, 69);
        bus_rd(14, d); chk("R6", "level6 ack", d, 69);
        bus_rd(10, d); chk("R6", "empty level2 spurious", d, 32'h18);

        // R4: processor mask comparison and one-clock latency
        @(negedge clk); cpu_mask = 6;
        chk("R4", "before edge still 6", 32'(irq_level), 6);
        @(negedge clk); chk("R4", "mask 6 blocks level 6", 32'(irq_level), 0);
        cpu_mask = 5;
        @(negedge clk); chk("R4", "mask 5 passes level 6", 32'(irq_level), 6);

        // R2: level 0 source never wins
        irq_pend[63] = 1;
        bus_rd(8, d);  chk("R2", "level0 src63 ignored", d, 69);
        bus_wr(64 + 63, 7);
        bus_rd(8, d);  chk("R3", "level7 src63 wins", d, 127);
        chk("R4", "irq_level 7", 32'(irq_level), 7);

        // R7: writes to acknowledge addresses
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 7'd8; bus_wdata = 32'hffff_ffff;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; e = bus_err;
        chk("R7", "err on swack write", 32'(e), 1);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 7'd12; bus_wdata = 32'h0;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; e = bus_err;
        chk("R7", "err on level ack write", 32'(e), 1);
        bus_rd(0, d);  chk("R7", "mask unchanged", d, 0);
        bus_rd(4, d);  chk("R7", "force unchanged", d, 32'h20);
        bus_rd(8, d);  chk("R7", "winner unchanged", d, 127);
        bus_wr(0, 32'h0); e = bus_err;
        chk("R7", "no err on normal write", 32'(e), 0);

        // R5: nothing pending gives spurious vector
        irq_pend = '0;
        bus_wr(4, 32'h0);
        bus_rd(8, d);  chk("R5", "spurious when idle", d, 32'h18);
        chk("R4", "irq_level idle", 32'(irq_level), 0);

        // R10: back-to-back requests each acknowledged
        @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = 7'd0;
        @(negedge clk); chk("R10", "ack 1", 32'(bus_ack), 1);
        @(negedge clk); bus_valid = 0;
        chk("R10", "ack 2", 32'(bus_ack), 1);
        @(negedge clk); chk("R10", "ack drops", 32'(bus_ack), 0);

        repeat (3) step();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule